// File: doc/BRIEF.md
# LCD frame start sequencer

This block opens every frame of an LCD refresh. When software raises the enable level, the block checks the frame buffer addresses held by a companion DMA channel. A channel holds one buffer (start and end address) in single mode or two buffers in dual mode. If any address lies outside the legal memory window, the block raises an address fault towards the channel and switches itself off.

On each frame tick the block reads a palette of `PAL_N` halfwords from the base of the current buffer, unless the load mode forbids it. It streams each word to an external palette RAM. It keeps bits 14:12 of the first word as the depth code. From that code it derives the pixel depth and the offset of the pixel data past the buffer base. It then checks that the header plus the pixel data fit inside the buffer. A frame that fits is launched: the block reports the pixel start address, the depth and the line window, marks the buffer done at the channel, and moves on to the other buffer in dual mode. A frame that does not fit raises a sync error and switches the block off.

Unpacking pixels and driving the panel are the job of later stages.

Top module: `lcd_frame_seq`

## Requirements
- R1: On a rising edge of `cfg_enable` the block checks `dma_top0` and `dma_bot0`, and also `dma_top1` and `dma_bot1` when `dma_dual` is 1, against the inclusive window `MEM_LO`..`MEM_HI`. If any checked address lies outside the window, it pulses `dma_cond_set[2]` for one cycle, pulses `dma_irq` if `dma_ie[1]` is 1, and leaves `ctl_on` at 0.
- R2: In load modes 0 and 3, each frame tick reads `PAL_N` halfwords at byte addresses base+2*i in ascending order. Base is the top address of the current buffer. Each word appears on `pal_data` with `pal_idx`=i while `pal_we` is 1. `pal_done` is 1 from the last word until the next enable.
- R3: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays unchanged. Only one read is outstanding at a time, and its word returns on a later cycle with `rsp_valid`.
- R4: In load mode 1, frame ticks cause no read, no frame launch and no DMA mark. In load mode 2, a frame tick issues no read and uses the depth code from the most recent palette load.
- R5: The depth code is bits 14:12 of palette word 0. Codes 1, 2 and 3 give 2, 4 and 8 bits per pixel. Codes 4 to 7 give 16 bits per pixel, with `frame_12b` = 1 when `cfg_tft` is 0. Code 0 launches no frame.
- R6: `frame_addr` is base+`PAL_N`*2 for depth codes 3 to 7 and base+`SHORT_OFF` for codes 1 and 2. In load mode 2 it is base+0.
- R7: If offset + width*height*bpp/8 is greater than (bottom - top) + 2, the block sets `sync_err`, clears `ctl_on` and launches no frame. Width is `cfg_width_m1`+1 and height is `cfg_height_m1`+1.
- R8: A launched frame pulses `frame_go` and `dma_cond_set[b]` for one cycle together, where b is the current buffer shown on `frame_buf`. It pulses `dma_irq` if `dma_ie[0]` is 1. It switches to the other buffer when `dma_dual` is 1.
- R9: With `sub_en` 0, `frame_first` is 0 and `frame_lines` is `cfg_height_m1`+1. With `sub_en` 1 and `sub_first` 1, `frame_first` is `sub_lines`. With `sub_en` 1 and `sub_first` 0, `frame_lines` is `sub_lines`.
- R10: A falling edge of `cfg_enable` clears `ctl_on` and `sync_err`, stops any palette read, and sets `frame_done` unless the load mode is 1. The next enable clears `frame_done` and `pal_done` and starts at buffer 0.
- R11: After reset, `ctl_on`, `sync_err`, `pal_done`, `frame_done`, `rd_valid`, `frame_go` and `dma_cond_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enable level; edges start and stop the sequencer |
| cfg_mode | input | 2 | Load mode: 1 no output, 2 no palette read |
| cfg_tft | input | 1 | Active-matrix panel; selects full 16-bit colour |
| cfg_width_m1 | input | CW | Panel width minus one |
| cfg_height_m1 | input | CW | Panel height minus one |
| sub_en | input | 1 | Sub-panel window enable |
| sub_first | input | 1 | Sub-panel value is first line (1) or line count (0) |
| sub_lines | input | CW | Sub-panel line value |
| frame_tick | input | 1 | Start-of-frame request |
| dma_dual | input | 1 | Two frame buffers in use |
| dma_ie | input | 2 | Channel interrupt enables: bit 0 frame, bit 1 address fault |
| dma_top0 | input | AW | Buffer 0 start address |
| dma_bot0 | input | AW | Buffer 0 end address |
| dma_top1 | input | AW | Buffer 1 start address |
| dma_bot1 | input | AW | Buffer 1 end address |
| dma_cond_set | output | 3 | One-cycle condition marks: bits 1:0 buffer done, bit 2 address fault |
| dma_irq | output | 1 | One-cycle channel interrupt pulse |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | AW | Read byte address |
| rsp_valid | input | 1 | Read word returned |
| rsp_data | input | DW | Returned word |
| pal_we | output | 1 | Palette RAM write strobe |
| pal_idx | output | log2(PAL_N) | Palette entry index |
| pal_data | output | DW | Palette entry value |
| frame_go | output | 1 | One-cycle frame launch |
| frame_addr | output | AW | First pixel byte address |
| frame_bpp | output | 5 | Bits per pixel |
| frame_12b | output | 1 | 16-bit pixels carry 12-bit colour |
| frame_first | output | CW | First displayed line |
| frame_lines | output | CW+1 | Displayed line count |
| frame_buf | output | 1 | Buffer of the launched frame |
| ctl_on | output | 1 | Sequencer switched on |
| pal_done | output | 1 | Palette loaded since enable |
| frame_done | output | 1 | Frame stream stopped by disable |
| sync_err | output | 1 | Frame did not fit its buffer |

## Verification
The bench builds the block with a 16-bit address, a 4-bit dimension field (4x4 panel), a 16-entry palette and a short header offset of 8 bytes. These values make the two header offsets (32 and 8 bytes) distinct and keep every palette load short. That makes it cheap to sweep all eight depth codes against both panel types, in the full load mode and again in the mode that skips the palette read. The small window also puts the size limit at exact byte values, so the frames one byte under and one byte over the limit are each checked. Dual-buffer alternation, address faults on either buffer and the sub-panel variants are run on the same configuration.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PAL,
        ST_DECODE,
        ST_SIZE,
        ST_RUN
    } seq_state_e;

    localparam logic [1:0] LOAD_NO_OUTPUT  = 2'd1;
    localparam logic [1:0] LOAD_NO_PALETTE = 2'd2;

    // position of the 3-bit depth code inside palette word 0
    localparam int DEPTH_LSB = 12;

    typedef struct packed {
        logic       ok;          // code names a supported depth
        logic [4:0] bpp;         // bits per pixel
        logic       low_colour;  // 16-bit pixels hold 12-bit colour
        logic       wide_hdr;    // full palette precedes pixel data
    } depth_t;

    function automatic depth_t decode_depth(input logic [2:0] code, input logic tft);
        depth_t d;
        d = '0;
        unique case (code)
            3'd0: d.ok = 1'b0;
            3'd1: begin d.ok = 1'b1; d.bpp = 5'd2; end
            3'd2: begin d.ok = 1'b1; d.bpp = 5'd4; end
            3'd3: begin d.ok = 1'b1; d.bpp = 5'd8; d.wide_hdr = 1'b1; end
            default: begin
                d.ok         = 1'b1;
                d.bpp        = 5'd16;
                d.wide_hdr   = 1'b1;
                d.low_colour = ~tft;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lcdseq_addr_window.sv
module lcdseq_addr_window #(
    parameter int             AW = 32,
    parameter int             N  = 4,
    parameter logic [AW-1:0]  LO = 32'h1000_0000,
    parameter logic [AW-1:0]  HI = 32'h1FFF_FFFF
) (
    input  logic [N-1:0][AW-1:0] addrs,
    input  logic [N-1:0]         check_mask,
    output logic                 all_ok
);
    logic [N-1:0] bad;

    for (genvar i = 0; i < N; i++) begin : g_addr
        assign bad[i] = check_mask[i] && ((addrs[i] < LO) || (addrs[i] > HI));
    end

    assign all_ok = ~|bad;
endmodule

// File: rtl/lcdseq_pal_loader.sv
module lcdseq_pal_loader
    import lcdseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 16,
    parameter int PAL_N = 256,
    localparam int PIW  = $clog2(PAL_N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           abort,
    input  logic [AW-1:0]  base,
    output logic           rd_valid,
    input  logic           rd_ready,
    output logic [AW-1:0]  rd_addr,
    input  logic           rsp_valid,
    input  logic [DW-1:0]  rsp_data,
    output logic           pal_we,
    output logic [PIW-1:0] pal_idx,
    output logic [DW-1:0]  pal_data,
    output logic           load_done,
    output logic [2:0]     hdr_code
);
    localparam int             BPW  = DW / 8;
    localparam logic [PIW-1:0] LAST = PIW'(PAL_N - 1);

    logic           busy;
    logic           waiting;
    logic [PIW-1:0] idx;
    logic [AW-1:0]  base_q;
    logic           accept;

    assign rd_valid  = busy & ~waiting;
    assign rd_addr   = base_q + AW'(idx) * AW'(BPW);
    assign accept    = busy & waiting & rsp_valid;
    assign pal_we    = accept;
    assign pal_idx   = idx;
    assign pal_data  = rsp_data;
    assign load_done = accept && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            waiting  <= 1'b0;
            idx      <= '0;
            base_q   <= '0;
            hdr_code <= '0;
        end else if (abort) begin
            busy    <= 1'b0;
            waiting <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            waiting <= 1'b0;
            idx     <= '0;
            base_q  <= base;
        end else begin
            if (rd_valid && rd_ready) begin
                waiting <= 1'b1;
            end
            if (accept) begin
                waiting <= 1'b0;
                if (idx == '0) begin
                    hdr_code <= rsp_data[DEPTH_LSB +: 3];
                end
                if (idx == LAST) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lcdseq_frame_sizer.sv
module lcdseq_frame_sizer
    import lcdseq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 10,
    parameter int PAL_BYTES = 512,
    parameter int SHORT_OFF = 32
) (
    input  logic [2:0]    code,
    input  logic          tft,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] w_m1,
    input  logic [CW-1:0] h_m1,
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] bot,
    output depth_t        dep,
    output logic [AW-1:0] offset,
    output logic          fits
);
    localparam int NW = AW + 2 * CW + 8;

    logic [NW-1:0] wv, hv, pix_bits, need;

    assign dep = decode_depth(code, tft);

    always_comb begin
        if (mode == LOAD_NO_PALETTE) begin
            offset = '0;
        end else if (dep.wide_hdr) begin
            offset = AW'(PAL_BYTES);
        end else begin
            offset = AW'(SHORT_OFF);
        end
    end

    assign wv       = NW'(w_m1) + NW'(1);
    assign hv       = NW'(h_m1) + NW'(1);
    assign pix_bits = wv * hv * NW'(dep.bpp);
    assign need     = NW'(offset) + (pix_bits >> 3);
    assign fits     = (need + NW'(top)) <= (NW'(bot) + NW'(2));
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcdseq_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            DW        = 16,
    parameter int            CW        = 10,
    parameter int            PAL_N     = 256,
    parameter int            SHORT_OFF = 32,
    parameter logic [AW-1:0] MEM_LO    = 32'h1000_0000,
    parameter logic [AW-1:0] MEM_HI    = 32'h1FFF_FFFF,
    localparam int           PIW       = $clog2(PAL_N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_enable,
    input  logic [1:0]     cfg_mode,
    input  logic           cfg_tft,
    input  logic [CW-1:0]  cfg_width_m1,
    input  logic [CW-1:0]  cfg_height_m1,
    input  logic           sub_en,
    input  logic           sub_first,
    input  logic [CW-1:0]  sub_lines,
    input  logic           frame_tick,
    input  logic           dma_dual,
    input  logic [1:0]     dma_ie,
    input  logic [AW-1:0]  dma_top0,
    input  logic [AW-1:0]  dma_bot0,
    input  logic [AW-1:0]  dma_top1,
    input  logic [AW-1:0]  dma_bot1,
    output logic [2:0]     dma_cond_set,
    output logic           dma_irq,
    output logic           rd_valid,
    input  logic           rd_ready,
    output logic [AW-1:0]  rd_addr,
    input  logic           rsp_valid,
    input  logic [DW-1:0]  rsp_data,
    output logic           pal_we,
    output logic [PIW-1:0] pal_idx,
    output logic [DW-1:0]  pal_data,
    output logic           frame_go,
    output logic [AW-1:0]  frame_addr,
    output logic [4:0]     frame_bpp,
    output logic           frame_12b,
    output logic [CW-1:0]  frame_first,
    output logic [CW:0]    frame_lines,
    output logic           frame_buf,
    output logic           ctl_on,
    output logic           pal_done,
    output logic           frame_done,
    output logic           sync_err
);
    localparam int PAL_BYTES = PAL_N * (DW / 8);

    seq_state_e    st;
    logic          en_q;
    logic          en_rise;
    logic          en_fall;
    logic          cur_buf;
    logic          addr_ok;
    logic          load_start;
    logic          load_done;
    logic [2:0]    hdr_code;
    logic [AW-1:0] cur_top;
    logic [AW-1:0] cur_bot;
    depth_t        dep;
    logic [AW-1:0] offset;
    logic          fits;

    assign en_rise = cfg_enable & ~en_q;
    assign en_fall = ~cfg_enable & en_q;
    assign cur_top = cur_buf ? dma_top1 : dma_top0;
    assign cur_bot = cur_buf ? dma_bot1 : dma_bot0;

    assign load_start = (st == ST_RUN) && frame_tick &&
                        (cfg_mode != LOAD_NO_OUTPUT) && (cfg_mode != LOAD_NO_PALETTE);

    lcdseq_addr_window #(
        .AW (AW),
        .N  (4),
        .LO (MEM_LO),
        .HI (MEM_HI)
    ) u_window (
        .addrs      ({dma_bot1, dma_top1, dma_bot0, dma_top0}),
        .check_mask ({dma_dual, dma_dual, 2'b11}),
        .all_ok     (addr_ok)
    );

    lcdseq_pal_loader #(
        .AW    (AW),
        .DW    (DW),
        .PAL_N (PAL_N)
    ) u_loader (
        .clk       (clk),
        .rst       (rst),
        .start     (load_start),
        .abort     (en_fall),
        .base      (cur_top),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_addr   (rd_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .pal_we    (pal_we),
        .pal_idx   (pal_idx),
        .pal_data  (pal_data),
        .load_done (load_done),
        .hdr_code  (hdr_code)
    );

    lcdseq_frame_sizer #(
        .AW        (AW),
        .CW        (CW),
        .PAL_BYTES (PAL_BYTES),
        .SHORT_OFF (SHORT_OFF)
    ) u_sizer (
        .code   (hdr_code),
        .tft    (cfg_tft),
        .mode   (cfg_mode),
        .w_m1   (cfg_width_m1),
        .h_m1   (cfg_height_m1),
        .top    (cur_top),
        .bot    (cur_bot),
        .dep    (dep),
        .offset (offset),
        .fits   (fits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            en_q         <= 1'b0;
            ctl_on       <= 1'b0;
            sync_err     <= 1'b0;
            pal_done     <= 1'b0;
            frame_done   <= 1'b0;
            cur_buf      <= 1'b0;
            dma_cond_set <= '0;
            dma_irq      <= 1'b0;
            frame_go     <= 1'b0;
            frame_addr   <= '0;
            frame_bpp    <= '0;
            frame_12b    <= 1'b0;
            frame_first  <= '0;
            frame_lines  <= '0;
            frame_buf    <= 1'b0;
        end else begin
            en_q         <= cfg_enable;
            dma_cond_set <= '0;
            dma_irq      <= 1'b0;
            frame_go     <= 1'b0;
            if (en_fall) begin
                st       <= ST_IDLE;
                ctl_on   <= 1'b0;
                sync_err <= 1'b0;
                cur_buf  <= 1'b0;
                if (cfg_mode != LOAD_NO_OUTPUT) begin
                    frame_done <= 1'b1;
                end
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (en_rise) begin
                            ctl_on     <= 1'b1;
                            frame_done <= 1'b0;
                            pal_done   <= 1'b0;
                            cur_buf    <= 1'b0;
                            st         <= ST_CHECK;
                        end
                    end
                    ST_CHECK: begin
                        if (!addr_ok) begin
                            dma_cond_set[2] <= 1'b1;
                            dma_irq         <= dma_ie[1];
                            ctl_on          <= 1'b0;
                            st              <= ST_IDLE;
                        end else begin
                            st <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (frame_tick && (cfg_mode != LOAD_NO_OUTPUT)) begin
                            st <= (cfg_mode == LOAD_NO_PALETTE) ? ST_DECODE : ST_PAL;
                        end
                    end
                    ST_PAL: begin
                        if (load_done) begin
                            pal_done <= 1'b1;
                            st       <= ST_DECODE;
                        end
                    end
                    ST_DECODE: begin
                        st <= dep.ok ? ST_SIZE : ST_RUN;
                    end
                    ST_SIZE: begin
                        if (!fits) begin
                            sync_err <= 1'b1;
                            ctl_on   <= 1'b0;
                            st       <= ST_IDLE;
                        end else begin
                            frame_go   <= 1'b1;
                            frame_addr <= cur_top + offset;
                            frame_bpp  <= dep.bpp;
                            frame_12b  <= dep.low_colour;
                            frame_buf  <= cur_buf;
                            if (sub_en && sub_first) begin
                                frame_first <= sub_lines;
                            end else begin
                                frame_first <= '0;
                            end
                            if (sub_en && !sub_first) begin
                                frame_lines <= {1'b0, sub_lines};
                            end else begin
                                frame_lines <= {1'b0, cfg_height_m1} + 1'b1;
                            end
                            dma_cond_set[{1'b0, cur_buf}] <= 1'b1;
                            dma_irq    <= dma_ie[0];
                            if (dma_dual) begin
                                cur_buf <= ~cur_buf;
                            end
                            st <= ST_RUN;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcdseq_chk.sv
module lcdseq_chk #(
    parameter int AW    = 32,
    parameter int PAL_N = 256,
    parameter int PIW   = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_enable,
    input logic           ctl_on,
    input logic           sync_err,
    input logic           pal_done,
    input logic [2:0]     dma_cond_set,
    input logic           frame_go,
    input logic [4:0]     frame_bpp,
    input logic           frame_buf,
    input logic           rd_valid,
    input logic           rd_ready,
    input logic [AW-1:0]  rd_addr,
    input logic           pal_we,
    input logic [PIW-1:0] pal_idx
);
    AST_FAULT_LEAVES_OFF: assert property (@(posedge clk) disable iff (rst)
        dma_cond_set[2] |-> !ctl_on); // R1

    AST_PAL_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(pal_done) |-> ($past(pal_we) && ($past(pal_idx) == PIW'(PAL_N - 1)))); // R2

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && cfg_enable) |=> (rd_valid && $stable(rd_addr))); // R3

    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        frame_go |-> (frame_bpp == 5'd2 || frame_bpp == 5'd4 ||
                      frame_bpp == 5'd8 || frame_bpp == 5'd16)); // R5

    AST_SYNC_STOPS: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> (!ctl_on && !frame_go)); // R7

    AST_GO_MARKS_BUFFER: assert property (@(posedge clk) disable iff (rst)
        frame_go |-> (dma_cond_set[frame_buf] && !dma_cond_set[~frame_buf] && ctl_on)); // R8

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl_on |-> (!frame_go && !rd_valid)); // R10
endmodule

bind lcd_frame_seq lcdseq_chk #(
    .AW    (AW),
    .PAL_N (PAL_N),
    .PIW   (PIW)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_enable   (cfg_enable),
    .ctl_on       (ctl_on),
    .sync_err     (sync_err),
    .pal_done     (pal_done),
    .dma_cond_set (dma_cond_set),
    .frame_go     (frame_go),
    .frame_bpp    (frame_bpp),
    .frame_buf    (frame_buf),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_addr      (rd_addr),
    .pal_we       (pal_we),
    .pal_idx      (pal_idx)
);

// File: tb/test_lcd_frame_seq.sv
module test_lcd_frame_seq;
    localparam int AW        = 16;
    localparam int DW        = 16;
    localparam int CW        = 4;
    localparam int PAL_N     = 16;
    localparam int PIW       = 4;
    localparam int SHORT_OFF = 8;
    localparam int PAL_BYTES = PAL_N * 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_enable = 1'b0;
    logic [1:0]     cfg_mode = 2'd0;
    logic           cfg_tft = 1'b0;
    logic [CW-1:0]  cfg_width_m1 = 4'd3;
    logic [CW-1:0]  cfg_height_m1 = 4'd3;
    logic           sub_en = 1'b0;
    logic           sub_first = 1'b0;
    logic [CW-1:0]  sub_lines = '0;
    logic           frame_tick = 1'b0;
    logic           dma_dual = 1'b0;
    logic [1:0]     dma_ie = 2'b00;
    logic [AW-1:0]  dma_top0 = 16'h2000;
    logic [AW-1:0]  dma_bot0 = 16'h2100;
    logic [AW-1:0]  dma_top1 = 16'h3000;
    logic [AW-1:0]  dma_bot1 = 16'h3100;
    logic [2:0]     dma_cond_set;
    logic           dma_irq;
    logic           rd_valid;
    logic           rd_ready = 1'b0;
    logic [AW-1:0]  rd_addr;
    logic           rsp_valid = 1'b0;
    logic [DW-1:0]  rsp_data = '0;
    logic           pal_we;
    logic [PIW-1:0] pal_idx;
    logic [DW-1:0]  pal_data;
    logic           frame_go;
    logic [AW-1:0]  frame_addr;
    logic [4:0]     frame_bpp;
    logic           frame_12b;
    logic [CW-1:0]  frame_first;
    logic [CW:0]    frame_lines;
    logic           frame_buf;
    logic           ctl_on;
    logic           pal_done;
    logic           frame_done;
    logic           sync_err;

    lcd_frame_seq #(
        .AW(AW), .DW(DW), .CW(CW), .PAL_N(PAL_N), .SHORT_OFF(SHORT_OFF),
        .MEM_LO(16'h1000), .MEM_HI(16'hEFFF)
    ) i_lcd_frame_seq (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [2:0] code0 = 3'd0;
    logic [2:0] code1 = 3'd0;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        if (a == dma_top0) return {1'b0, code0, 12'h5A1};
        if (a == dma_top1) return {1'b0, code1, 12'h3C2};
        return a ^ 16'hA55A;
    endfunction

    // memory model: ready pattern and one-cycle response
    int rdy_cnt = 0;
    always @(posedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        rd_ready  <= (rdy_cnt % 3) != 2;
        rsp_valid <= rd_valid && rd_ready;
        rsp_data  <= mem_word(rd_addr);
    end

    // monitor
    logic [15:0] exp_base = 16'h2000;
    int pal_cnt, rd_cnt, addr_err, data_err, hs_err, go_cnt, irq_cnt;
    int cond_cnt [3];
    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0;
    logic [15:0] g_addr;
    logic [4:0]  g_bpp;
    logic        g_12b, g_buf;
    logic [CW-1:0] g_first;
    logic [CW:0]   g_lines;

    always @(negedge clk) begin
        if (!rst) begin
            if (pend && !(rd_valid && rd_addr == pend_addr)) hs_err++;
            pend      = rd_valid && !rd_ready;
            pend_addr = rd_addr;
            if (rd_valid && rd_ready) begin
                if (rd_addr != exp_base + 16'(2 * rd_cnt)) addr_err++;
                rd_cnt++;
            end
            if (pal_we) begin
                if (int'(pal_idx) != pal_cnt) data_err++;
                if (pal_data != mem_word(exp_base + 16'(2 * pal_cnt))) data_err++;
                pal_cnt++;
            end
            if (frame_go) begin
                go_cnt++;
                g_addr = frame_addr; g_bpp = frame_bpp; g_12b = frame_12b;
                g_buf = frame_buf; g_first = frame_first; g_lines = frame_lines;
            end
            for (int k = 0; k < 3; k++) if (dma_cond_set[k]) cond_cnt[k]++;
            if (dma_irq) irq_cnt++;
        end
    end

    task automatic clear_counts();
        pal_cnt = 0; rd_cnt = 0; addr_err = 0; data_err = 0; go_cnt = 0; irq_cnt = 0;
        for (int k = 0; k < 3; k++) cond_cnt[k] = 0;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic turn_on();
        @(negedge clk) cfg_enable = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic turn_off();
        @(negedge clk) cfg_enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        repeat (120) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clear_counts();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11", "ctl_on", ctl_on, 0);
        chk("R11", "sync_err", sync_err, 0);
        chk("R11", "pal_done", pal_done, 0);
        chk("R11", "frame_done", frame_done, 0);
        chk("R11", "rd_valid", rd_valid, 0);
        chk("R11", "frame_go/cond", {frame_go, dma_cond_set}, 0);

        // R1 address faults
        clear_counts();
        dma_ie = 2'b10; dma_top0 = 16'h0100;
        turn_on();
        chk("R1", "fault mark buf0", cond_cnt[2], 1);
        chk("R1", "fault irq", irq_cnt, 1);
        chk("R1", "ctl_on after fault", ctl_on, 0);
        turn_off();
        clear_counts();
        dma_top0 = 16'h2000; dma_dual = 1'b1; dma_top1 = 16'hF800; dma_ie = 2'b00;
        turn_on();
        chk("R1", "fault mark buf1", cond_cnt[2], 1);
        chk("R1", "no irq when disabled", irq_cnt, 0);
        chk("R1", "ctl_on dual fault", ctl_on, 0);
        turn_off();
        clear_counts();
        dma_dual = 1'b0;
        turn_on();
        chk("R1", "buf1 ignored in single", cond_cnt[2], 0);
        chk("R1", "ctl_on single", ctl_on, 1);
        turn_off();
        dma_top1 = 16'h3000;

        // R2 R4 R5 R6 sweep over depth codes and panel type
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 2; t++) begin
                int  ebpp;
                bit  eok;
                bit  e12;
                int  eoff;
                eok  = (c != 0);
                ebpp = (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 8 : 16;
                e12  = (c >= 4) && (t == 0);
                eoff = (c >= 3) ? PAL_BYTES : SHORT_OFF;
                clear_counts();
                code0 = 3'(c); cfg_tft = t[0]; cfg_mode = 2'd0; exp_base = dma_top0;
                turn_on();
                tick();
                chk("R2", "palette words", pal_cnt, PAL_N);
                chk("R2", "palette addr/data errors", addr_err + data_err, 0);
                chk("R2", "pal_done", pal_done, 1);
                chk("R5", "frame launched", go_cnt, eok);
                if (eok) begin
                    chk("R5", "bpp", g_bpp, ebpp);
                    chk("R5", "12-bit colour", g_12b, e12);
                    chk("R6", "pixel address", g_addr, 16'h2000 + eoff);
                    chk("R8", "buffer 0 mark", cond_cnt[0], 1);
                end
                // load mode 2: no read, held depth code, offset 0
                clear_counts();
                cfg_mode = 2'd2; code0 = 3'(c + 1);
                tick();
                chk("R4", "mode 2 reads", rd_cnt, 0);
                chk("R4", "mode 2 launch", go_cnt, eok);
                if (eok) begin
                    chk("R4", "mode 2 held bpp", g_bpp, ebpp);
                    chk("R6", "mode 2 address", g_addr, 16'h2000);
                end
                turn_off();
            end
        end
        cfg_mode = 2'd0; cfg_tft = 1'b0;

        // R7 size boundary, 8 bpp 4x4: need 48 bytes
        clear_counts();
        code0 = 3'd3; dma_bot0 = 16'h2000 + 16'd46; exp_base = dma_top0;
        turn_on();
        tick();
        chk("R7", "exact fit launches", go_cnt, 1);
        chk("R7", "exact fit no error", sync_err, 0);
        turn_off();
        clear_counts();
        dma_bot0 = 16'h2000 + 16'd45;
        turn_on();
        tick();
        chk("R7", "one byte short error", sync_err, 1);
        chk("R7", "one byte short off", ctl_on, 0);
        chk("R7", "one byte short no launch", go_cnt, 0);
        turn_off();
        chk("R10", "disable clears sync_err", sync_err, 0);
        chk("R10", "disable sets frame_done", frame_done, 1);
        dma_bot0 = 16'h2100;

        // R8 dual buffers
        clear_counts();
        dma_dual = 1'b1; dma_ie = 2'b01; code0 = 3'd1; code1 = 3'd4; cfg_tft = 1'b1;
        turn_on();
        chk("R10", "enable clears frame_done", frame_done, 0);
        exp_base = dma_top0; tick();
        chk("R8", "first frame buffer", g_buf, 0);
        chk("R8", "first frame address", g_addr, 16'h2000 + SHORT_OFF);
        chk("R8", "first frame irq", irq_cnt, 1);
        clear_counts();
        exp_base = dma_top1; tick();
        chk("R8", "second frame buffer", g_buf, 1);
        chk("R8", "second frame mark", cond_cnt[1], 1);
        chk("R8", "second frame address", g_addr, 16'h3000 + PAL_BYTES);
        chk("R8", "second frame bpp", g_bpp, 16);
        chk("R8", "second frame 12b with tft", g_12b, 0);
        clear_counts();
        exp_base = dma_top0; tick();
        chk("R8", "third frame wraps", g_buf, 0);
        clear_counts();
        exp_base = dma_top1; tick();
        chk("R8", "fourth frame buffer", g_buf, 1);
        turn_off();
        clear_counts();
        turn_on();
        exp_base = dma_top0; tick();
        chk("R10", "restart at buffer 0", g_buf, 0);
        chk("R10", "restart palette ok", addr_err + data_err, 0);
        turn_off();
        dma_dual = 1'b0; dma_ie = 2'b00; cfg_tft = 1'b0;

        // R4 mode 1
        clear_counts();
        cfg_mode = 2'd1;
        turn_on();
        tick();
        chk("R4", "mode 1 reads", rd_cnt, 0);
        chk("R4", "mode 1 launches", go_cnt, 0);
        chk("R4", "mode 1 marks", cond_cnt[0] + cond_cnt[1], 0);
        turn_off();
        chk("R10", "mode 1 disable keeps frame_done", frame_done, 0);
        cfg_mode = 2'd0;

        // R9 sub-panel
        code0 = 3'd3; exp_base = dma_top0;
        turn_on();
        sub_en = 1'b1; sub_first = 1'b0; sub_lines = 4'd2;
        tick();
        chk("R9", "override lines", g_lines, 2);
        chk("R9", "override first", g_first, 0);
        clear_counts();
        sub_first = 1'b1; sub_lines = 4'd2;
        tick();
        chk("R9", "first line", g_first, 2);
        chk("R9", "first line count", g_lines, 4);
        clear_counts();
        sub_en = 1'b0; sub_lines = 4'd7;
        tick();
        chk("R9", "window off first", g_first, 0);
        chk("R9", "window off lines", g_lines, 4);
        turn_off();

        chk("R3", "read handshake violations", hs_err, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule